// File: doc/BRIEF.md
# Write-Through Snoopy Coherence Controller

This block keeps one processor's cache coherent with the other caches on a shared bus. The protocol has two line states, Valid and Invalid. Writes always go straight through to memory, and a write that misses does not bring the line into the cache. The controller holds the state and tag of every line of a direct-mapped cache. It turns processor requests into bus reads and bus writes, waits for the arbiter's grant and the transfer acknowledge, and then tells the processor the request is done. It also watches the writes that other agents put on the bus and invalidates its own copy of any line they touch.

The data array, the memory and the bus arbiter sit outside the block. The data path follows the controller's decisions. A fill happens when a bus read is acknowledged. Write data leaves the cache on every bus write.

A read that has left for the bus can be overtaken by another agent's write to the same line before the data returns. In that case the fetched copy is not kept, so the cache never holds data that another agent has already overwritten.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and `bus_req` and `cpu_done` are low.
- R2: A processor read that misses raises `bus_req` with `bus_write`=0 and the request address in the cycle after acceptance. On acknowledge the line becomes Valid, and `cpu_done` pulses for one cycle in the cycle after the acknowledge.
- R3: A processor read that hits a Valid line with a matching tag makes no bus request, and `cpu_done` pulses in the cycle right after acceptance.
- R4: Every processor write raises `bus_req` with `bus_write`=1 and the request address in the cycle after acceptance, whatever the line's state. `cpu_done` follows one cycle after the acknowledge.
- R5: A write to an Invalid line leaves it Invalid, so a following read of that line goes to the bus.
- R6: A write to a Valid line keeps it Valid, so a following read of that line hits.
- R7: A snooped write (`snp_valid`=1, `snp_write`=1) whose line address matches a Valid line makes that line Invalid.
- R8: A snooped read (`snp_write`=0) changes no line state.
- R9: If a snooped write to a line arrives in the same cycle that a read of that line is accepted, the invalidation applies first and the read goes to the bus.
- R10: The line index is address bits [OFF_W +: IDX_W], and the tag is the bits above the index. A read with the same index but a different tag misses and replaces the line. A snooped write with the same index but a different tag has no effect.
- R11: While a bus operation is outstanding, `cpu_ready` is low. `bus_req`, `bus_addr` and `bus_write` stay steady until `bus_gnt`.
- R12: A snooped write to the line of an outstanding read miss, arriving at any point from the cycle after acceptance to the acknowledge cycle, leaves the line Invalid after the fill. The read still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor byte address |
| cpu_ready | output | 1 | Request accepted when high together with cpu_req_valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_write | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_ack | input | 1 | Transaction finished |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_write | input | 1 | Snooped transaction is a write |
| snp_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the snooped transaction |

## Verification
A read hit is due exactly one cycle after acceptance. A read miss or a write shows `bus_req` one cycle after acceptance and `cpu_done` exactly one cycle after the acknowledge cycle. The bench drives inputs and samples outputs on the falling edge. Its arbiter records the cycle number of every acknowledge, so completions are compared against that number rather than found by waiting. Each bus grant pops the scoreboard entry predicted from a line-state model kept in the bench, which checks the command and address at grant time.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

  localparam logic BUS_CMD_READ  = 1'b0;
  localparam logic BUS_CMD_WRITE = 1'b1;

endpackage

// File: rtl/wtsc_tag_array.sv
module wtsc_tag_array #(
  parameter int LINE_W    = 14,
  parameter int NUM_LINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lk_line,
  output logic              lk_hit,
  input  logic              snp_kill,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = LINE_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [LINE_W-1:0] ln);
    return ln[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] ln);
    return ln[LINE_W-1:IDX_W];
  endfunction

  logic [NUM_LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [TAG_W-1:0]     tag_d [NUM_LINES];

  logic snp_hit;
  logic lk_present;

  // snoop write matching a resident line
  assign snp_hit = snp_kill && valid_q[idx_of(snp_line)] &&
                   (tag_q[idx_of(snp_line)] == tag_of(snp_line));

  assign lk_present = valid_q[idx_of(lk_line)] &&
                      (tag_q[idx_of(lk_line)] == tag_of(lk_line));

  // a same-cycle invalidation of the looked-up line wins over the lookup
  assign lk_hit = lk_present && !(snp_hit && (snp_line == lk_line));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] LINE_IDX = IDX_W'(i);
    logic fill_here;
    logic kill_here;
    assign fill_here  = fill_en && (idx_of(fill_line) == LINE_IDX);
    assign kill_here  = snp_hit && (idx_of(snp_line) == LINE_IDX);
    assign valid_d[i] = fill_here ? 1'b1 : (kill_here ? 1'b0 : valid_q[i]);
    assign tag_d[i]   = fill_here ? tag_of(fill_line) : tag_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int k = 0; k < NUM_LINES; k++) tag_q[k] <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

endmodule

// File: rtl/wtsc_bus_seq.sv
module wtsc_bus_seq
  import wtsc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              bus_gnt,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              busy,
  output logic              xfer_done
);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;

  always_comb begin
    state_d   = state_q;
    xfer_done = 1'b0;
    case (state_q)
      SEQ_IDLE: if (start)   state_d = SEQ_REQ;
      SEQ_REQ:  if (bus_gnt) state_d = SEQ_WAIT;
      SEQ_WAIT: if (bus_ack) begin
        state_d   = SEQ_IDLE;
        xfer_done = 1'b1;
      end
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      write_q <= BUS_CMD_READ;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && start) begin
        addr_q  <= start_addr;
        write_q <= start_write;
      end
    end
  end

  assign bus_req   = (state_q == SEQ_REQ);
  assign bus_write = write_q;
  assign bus_addr  = addr_q;
  assign busy      = (state_q != SEQ_IDLE);

endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
  import wtsc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_LINES  = 16,
  parameter int LINE_BYTES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cpu_req_valid,
  input  logic                                  cpu_req_write,
  input  logic [ADDR_W-1:0]                     cpu_req_addr,
  output logic                                  cpu_ready,
  output logic                                  cpu_done,
  output logic                                  bus_req,
  output logic                                  bus_write,
  output logic [ADDR_W-1:0]                     bus_addr,
  input  logic                                  bus_gnt,
  input  logic                                  bus_ack,
  input  logic                                  snp_valid,
  input  logic                                  snp_write,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  snp_line
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  // named internal events, observed by the bound checker
  logic ev_accept;
  logic ev_hit_accept;
  logic ev_miss_start;
  logic ev_stale_now;
  logic ev_fill;
  logic ev_xfer_done;

  logic lk_hit;
  logic snp_kill;
  logic busy;
  logic pend_stale_q;
  logic done_q;

  assign snp_kill = snp_valid && snp_write;

  wtsc_tag_array #(
    .LINE_W    (LINE_W),
    .NUM_LINES (NUM_LINES)
  ) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_line   (line_of(cpu_req_addr)),
    .lk_hit    (lk_hit),
    .snp_kill  (snp_kill),
    .snp_line  (snp_line),
    .fill_en   (ev_fill),
    .fill_line (line_of(bus_addr))
  );

  wtsc_bus_seq #(
    .ADDR_W (ADDR_W)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ev_miss_start),
    .start_write (cpu_req_write),
    .start_addr  (cpu_req_addr),
    .bus_gnt     (bus_gnt),
    .bus_ack     (bus_ack),
    .bus_req     (bus_req),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .busy        (busy),
    .xfer_done   (ev_xfer_done)
  );

  assign cpu_ready     = !busy;
  assign ev_accept     = cpu_req_valid && cpu_ready;
  assign ev_hit_accept = ev_accept && !cpu_req_write && lk_hit;
  assign ev_miss_start = ev_accept && !ev_hit_accept;

  // another agent writes the line we are still fetching
  assign ev_stale_now  = busy && snp_kill && (snp_line == line_of(bus_addr));

  // reads allocate, writes never do; an overtaken fill is dropped
  assign ev_fill = ev_xfer_done && (bus_write == BUS_CMD_READ) &&
                   !pend_stale_q && !ev_stale_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_stale_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      if (ev_miss_start)     pend_stale_q <= 1'b0;
      else if (ev_stale_now) pend_stale_q <= 1'b1;
      done_q <= ev_hit_accept || ev_xfer_done;
    end
  end

  assign cpu_done = done_q;

endmodule

// File: rtl/wtsc_checker.sv
module wtsc_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req_valid,
  input logic                    cpu_req_write,
  input logic [ADDR_W-1:0]       cpu_req_addr,
  input logic                    cpu_ready,
  input logic                    cpu_done,
  input logic                    bus_req,
  input logic                    bus_write,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_gnt,
  input logic                    snp_valid,
  input logic                    snp_write,
  input logic [ADDR_W-OFF_W-1:0] snp_line,
  input logic                    ev_hit_accept,
  input logic                    ev_xfer_done
);

  a_r3_hit_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit_accept |=> cpu_done && !bus_req);

  a_r2_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |=> cpu_done);

  a_r4_write_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_ready && cpu_req_write |=>
      bus_req && bus_write && (bus_addr == $past(cpu_req_addr)));

  a_r9_kill_before_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_ready && !cpu_req_write && snp_valid && snp_write &&
    (cpu_req_addr[ADDR_W-1:OFF_W] == snp_line) |=> bus_req && !bus_write);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);

  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_write));

endmodule

bind wt_snoop_ctrl wtsc_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_write (cpu_req_write),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_ready     (cpu_ready),
  .cpu_done      (cpu_done),
  .bus_req       (bus_req),
  .bus_write     (bus_write),
  .bus_addr      (bus_addr),
  .bus_gnt       (bus_gnt),
  .snp_valid     (snp_valid),
  .snp_write     (snp_write),
  .snp_line      (snp_line),
  .ev_hit_accept (ev_hit_accept),
  .ev_xfer_done  (ev_xfer_done)
);

// File: tb/wt_snoop_ctrl_tb_top.sv
module wt_snoop_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 16;
  localparam int NL         = 16;
  localparam int LB         = 4;
  localparam int OFF        = $clog2(LB);
  localparam int IW         = $clog2(NL);
  localparam int LW         = AW - OFF;
  localparam int TW         = LW - IW;
  localparam int ACK_LAT    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic          cpu_ready;
  logic          cpu_done;
  logic          bus_req;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic          bus_gnt = 1'b0;
  logic          bus_ack = 1'b0;
  logic          snp_valid = 1'b0;
  logic          snp_write = 1'b0;
  logic [LW-1:0] snp_line = '0;

  wt_snoop_ctrl #(.ADDR_W(AW), .NUM_LINES(NL), .LINE_BYTES(LB)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_line(snp_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic          wr;
    logic [AW-1:0] a;
    string         rq;
  } bus_item_t;

  bus_item_t     exp_q[$];
  int            n_checks = 0;
  int            n_errors = 0;
  int            cyc = 0;
  int            ack_cyc = -10;
  int            gnt_dly = 0;
  logic          mv [NL];
  logic [TW-1:0] mt [NL];
  logic          pend_active = 1'b0;
  logic          pend_stale = 1'b0;
  logic [LW-1:0] pend_line = '0;
  logic          finished = 1'b0;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  function automatic logic [LW-1:0] ln(input logic [AW-1:0] a);
    return a >> OFF;
  endfunction
  function automatic int midx(input logic [LW-1:0] l);
    return int'(l % NL);
  endfunction
  function automatic logic [TW-1:0] mtag(input logic [LW-1:0] l);
    return TW'(l / NL);
  endfunction

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_kill(input logic [LW-1:0] l);
    if (mv[midx(l)] && mt[midx(l)] == mtag(l)) mv[midx(l)] = 1'b0;
  endtask

  // arbiter, memory and bus scoreboard monitor
  initial begin
    bus_item_t it;
    logic [AW-1:0] held_a;
    logic held_w;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        held_a = bus_addr;
        held_w = bus_write;
        for (int k = 0; k < gnt_dly; k++) begin
          @(negedge clk);
          check("R11", "request steady before grant",
                {bus_req, bus_addr == held_a, bus_write == held_w}, 3'b111);
        end
        bus_gnt = 1'b1;
        if (exp_q.size() == 0) begin
          check("R3", "unexpected bus transaction", 1, 0);
        end else begin
          it = exp_q.pop_front();
          check(it.rq, "bus command", bus_write, it.wr);
          check(it.rq, "bus address", bus_addr, it.a);
        end
        @(negedge clk);
        bus_gnt = 1'b0;
        repeat (ACK_LAT) @(negedge clk);
        bus_ack = 1'b1;
        ack_cyc = cyc;
        @(negedge clk);
        bus_ack = 1'b0;
      end
    end
  end

  // driver: predicts the outcome, pushes expected bus items, checks completion timing
  task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input string rq,
                        input logic with_snp = 1'b0, input logic [LW-1:0] s_line = '0);
    logic hit;
    int   tmo;
    if (with_snp) model_kill(s_line);
    hit = !wr && mv[midx(ln(a))] && (mt[midx(ln(a))] == mtag(ln(a)));
    if (!hit) begin
      exp_q.push_back('{wr, a, rq});
      pend_active = 1'b1;
      pend_line   = ln(a);
      pend_stale  = 1'b0;
    end
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = a;
    if (with_snp) begin
      snp_valid = 1'b1;
      snp_write = 1'b1;
      snp_line  = s_line;
    end
    @(negedge clk);
    cpu_req_valid = 1'b0;
    snp_valid     = 1'b0;
    if (hit) begin
      check(rq, "done one cycle after hit", cpu_done, 1);
      check(rq, "no bus request on hit", bus_req, 0);
    end else begin
      check(rq, "bus request on miss or write", bus_req, 1);
      check("R11", "ready low while bus op outstanding", cpu_ready, 0);
      tmo = 0;
      while (!cpu_done && tmo < 100) begin
        @(negedge clk);
        tmo++;
      end
      check(rq, "done cycle relative to ack", cyc, ack_cyc + 1);
      pend_active = 1'b0;
      if (!wr) begin
        mv[midx(ln(a))] = !pend_stale;
        mt[midx(ln(a))] = mtag(ln(a));
      end
    end
  endtask

  task automatic snoop(input logic wr, input logic [LW-1:0] l);
    @(negedge clk);
    snp_valid = 1'b1;
    snp_write = wr;
    snp_line  = l;
    if (wr) begin
      model_kill(l);
      if (pend_active && pend_line == l) pend_stale = 1'b1;
    end
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    report();
  end

  localparam logic [AW-1:0] A_ADDR = 16'h0040; // index 0, tag 1
  localparam logic [AW-1:0] B_ADDR = 16'h0084; // index 1, tag 2
  localparam logic [AW-1:0] X_ADDR = 16'h0840; // index 0, tag 0x21
  localparam logic [AW-1:0] C_ADDR = 16'h1040; // index 0, tag 0x41
  localparam logic [AW-1:0] D_ADDR = 16'h00c8; // index 2, tag 3

  initial begin
    for (int i = 0; i < NL; i++) begin
      mv[i] = 1'b0;
      mt[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", cpu_ready, 1);
    check("R1", "no bus request after reset", bus_req, 0);
    check("R1", "no done after reset", cpu_done, 0);

    cpu_op(1'b0, A_ADDR, "R1");               // first read misses: all Invalid
    cpu_op(1'b0, A_ADDR, "R3");               // hit
    cpu_op(1'b0, A_ADDR + 16'd1, "R3");       // other byte, same line
    cpu_op(1'b0, A_ADDR, "R2");               // still a hit, labelled by model
    gnt_dly = 3;
    cpu_op(1'b1, A_ADDR, "R4");               // write to Valid, late grant
    gnt_dly = 0;
    cpu_op(1'b0, A_ADDR, "R6");               // kept Valid
    cpu_op(1'b1, B_ADDR, "R4");               // write to Invalid
    cpu_op(1'b0, B_ADDR, "R5");               // no allocation: misses
    cpu_op(1'b0, B_ADDR, "R2");               // now Valid: hit
    snoop(1'b0, ln(A_ADDR));
    cpu_op(1'b0, A_ADDR, "R8");               // snooped read ignored
    snoop(1'b1, ln(X_ADDR));
    cpu_op(1'b0, A_ADDR, "R10");              // other tag, same index: ignored
    snoop(1'b1, ln(A_ADDR));
    cpu_op(1'b0, A_ADDR, "R7");               // invalidated: miss
    cpu_op(1'b0, C_ADDR, "R10");              // conflicting tag misses
    cpu_op(1'b0, A_ADDR, "R10");              // replaced: misses again
    cpu_op(1'b0, A_ADDR, "R9", 1'b1, ln(A_ADDR)); // same-cycle kill
    cpu_op(1'b0, A_ADDR, "R9");               // refilled: hit
    fork
      cpu_op(1'b0, D_ADDR, "R2");
      begin
        repeat (3) @(negedge clk);
        snoop(1'b1, ln(D_ADDR));
      end
    join
    cpu_op(1'b0, D_ADDR, "R12");              // overtaken fill kept Invalid
    cpu_op(1'b0, D_ADDR, "R12");              // second fetch kept
    check("R2", "all expected bus transactions seen", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    report();
  end

endmodule